// File: doc/BRIEF.md
# Hashed Page-Table Entry Page-Size Decoder

This block takes a hashed page-table entry that the table search has already found, works out the page size it really maps, and forms the translated real address. The page size is not fixed by the segment. A large-page flag in the first doubleword selects the path. When the flag is clear, the entry maps a 4 KiB page, but only if the segment's base page is also 4 KiB. When the flag is set, the size is encoded in low bits of the real page number field in the second doubleword. That encoding is checked against an ordered per-segment list of candidate sizes, and each candidate carries its own encoding value.

The per-segment list and the segment base page shift are loaded through a write port. Each list slot holds a page shift and an encoding value. A lookup request carries both entry doublewords and the effective address. Exactly one cycle later the block returns four things: the decoded shift, a valid-translation or machine-check indication, the real address, and the mapping size for the translation cache. These results hold until the next request.

Top module: `pte_pgsize_xlate`

## Requirements
- R1: Reset is synchronous and active high. After reset, `rsp_valid`, `rsp_ok`, `rsp_mchk`, `rsp_shift`, `rsp_raddr` and `rsp_size` are all zero. Every list slot has shift 0, which means the list is empty, and the segment base shift is 12.
- R2: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high, and low otherwise. Outputs change only in a cycle that follows a request, and they hold their value otherwise. Back-to-back requests each get their own response.
- R3: When bit 2 of `req_pte0` (the large-page flag) is 0 and the segment base shift is 12, the result is shift 12 with `rsp_ok` high.
- R4: When bit 2 of `req_pte0` is 0 and the segment base shift is not 12, the result is shift 0.
- R5: When bit 2 of `req_pte0` is 1, the list slots are tried from index 0 upward, and the first slot that matches sets the shift.
- R6: A slot whose shift is 0 ends the list, so no slot at a higher index can match.
- R7: When bit 2 of `req_pte0` is 1, slots with shift 12 are never taken.
- R8: A slot with shift s and encoding e matches when the bits of `req_pte1` in positions 12 to min(s-1,55) equal `e<<12` in those same positions, and `e<<12` has no bits outside them.
- R9: When the large-page flag is set and no slot matches, the result is shift 0.
- R10: A result of shift 0 gives `rsp_mchk`=1 and `rsp_ok`=0, with `rsp_raddr` and `rsp_size` set to 0. Any other shift gives `rsp_ok`=1 and `rsp_mchk`=0.
- R11: On a valid result, `rsp_raddr` is `req_pte1` with bits 63:56 and 11:0 cleared, and with its low `rsp_shift` bits then replaced by the same bits of `req_ea`.
- R12: On a valid result, `rsp_size` equals 2 to the power `rsp_shift`.
- R13: A write with `cfg_we` stores `cfg_shift` and `cfg_enc` into slot `cfg_idx`. A write with `cfg_base_we` stores the segment base shift. Both writes apply to requests made in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one list slot |
| cfg_idx | input | 3 | Slot index to write |
| cfg_shift | input | 6 | Page shift for the slot (0 ends the list) |
| cfg_enc | input | 16 | Encoding value for the slot |
| cfg_base_we | input | 1 | Write the segment base page shift |
| cfg_base_shift | input | 6 | New segment base page shift |
| req_valid | input | 1 | Lookup request |
| req_pte0 | input | 64 | First entry doubleword; bit 2 is the large-page flag |
| req_pte1 | input | 64 | Second entry doubleword; bits 55:12 are the real page number |
| req_ea | input | 64 | Effective address |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_ok | output | 1 | Decoded page size is valid |
| rsp_mchk | output | 1 | Bad size encoding: machine check with error code zero |
| rsp_shift | output | 6 | Decoded page shift, 0 when bad |
| rsp_raddr | output | 64 | Real address |
| rsp_size | output | 64 | Mapping size in bytes |

## Verification
Suppose a list slot is stored at the wrong index, or a stale slot survives a rewrite. Nothing shows at the ports until a large-page request whose encoding reaches that slot. The bench therefore places overlapping encodings on both sides of a terminator and of a 4 KiB slot, so that a wrong scan order, a missed stop, or a missed skip shows up as a wrong `rsp_shift` in the very next response cycle. A wrong mask width shows up the same way, in `rsp_raddr` and `rsp_size`. A broken hold or valid path shows up one cycle after any idle or back-to-back request. The reference model is compared on every clock.

// File: rtl/pgsz_pkg.sv
package pgsz_pkg;
  localparam int unsigned XW        = 64;
  localparam int unsigned SHW       = 6;
  localparam int unsigned RPN_LO    = 12;
  localparam int unsigned RPN_HI    = 55;
  localparam int unsigned LARGE_BIT = 2;
  localparam int unsigned SMALL_SH  = 12;

  typedef logic [XW-1:0]  word_t;
  typedef logic [SHW-1:0] shift_t;

  // All ones in bits below s.
  function automatic word_t low_ones(input shift_t s);
    return (word_t'(1) << s) - word_t'(1);
  endfunction

  // Real page number field of the second doubleword.
  function automatic word_t rpn_field();
    word_t m;
    m = '0;
    for (int b = RPN_LO; b <= RPN_HI; b++) m[b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pgsz_enc_table.sv
module pgsz_enc_table
  import pgsz_pkg::*;
#(
  parameter int unsigned NUM_ENC = 8,
  parameter int unsigned ENC_W   = 16,
  localparam int unsigned IDX_W  = (NUM_ENC > 1) ? $clog2(NUM_ENC) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [IDX_W-1:0]              widx,
  input  logic [SHW-1:0]                wshift,
  input  logic [ENC_W-1:0]              wenc,
  input  logic                          base_we,
  input  logic [SHW-1:0]                base_wshift,
  output logic [NUM_ENC-1:0][SHW-1:0]   slot_shift,
  output logic [NUM_ENC-1:0][ENC_W-1:0] slot_enc,
  output logic [SHW-1:0]                base_shift
);
  logic [NUM_ENC-1:0][SHW-1:0]   sh_q;
  logic [NUM_ENC-1:0][ENC_W-1:0] en_q;
  logic [SHW-1:0]                base_q;

  for (genvar i = 0; i < NUM_ENC; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        sh_q[i] <= '0;
        en_q[i] <= '0;
      end else if (we && (widx == IDX_W'(i))) begin
        sh_q[i] <= wshift;
        en_q[i] <= wenc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          base_q <= SHW'(SMALL_SH);
    else if (base_we) base_q <= base_wshift;
  end

  assign slot_shift = sh_q;
  assign slot_enc   = en_q;
  assign base_shift = base_q;
endmodule

// File: rtl/pgsz_scan.sv
module pgsz_scan
  import pgsz_pkg::*;
#(
  parameter int unsigned NUM_ENC = 8,
  parameter int unsigned ENC_W   = 16
) (
  input  logic [XW-1:0]                 pte0,
  input  logic [XW-1:0]                 pte1,
  input  logic [SHW-1:0]                base_shift,
  input  logic [NUM_ENC-1:0][SHW-1:0]   slot_shift,
  input  logic [NUM_ENC-1:0][ENC_W-1:0] slot_enc,
  output logic [SHW-1:0]                shift_out
);
  localparam word_t RPN_M = rpn_field();

  logic [NUM_ENC-1:0] live;
  logic [NUM_ENC-1:0] cand;
  logic [SHW-1:0]     large_sh;

  for (genvar i = 0; i < NUM_ENC; i++) begin : g_cmp
    word_t msk, want;
    logic  hit;
    if (i == 0) begin : g_first
      assign live[i] = 1'b1;
    end else begin : g_rest
      assign live[i] = live[i-1] && (slot_shift[i-1] != '0);
    end
    assign msk  = low_ones(slot_shift[i]) & RPN_M;
    assign want = word_t'(slot_enc[i]) << RPN_LO;
    assign hit  = ((pte1 & msk) == want);
    assign cand[i] = live[i] && (slot_shift[i] != '0)
                   && (slot_shift[i] != SHW'(SMALL_SH)) && hit;
  end

  always_comb begin
    large_sh = '0;
    for (int k = NUM_ENC - 1; k >= 0; k--) begin
      if (cand[k]) large_sh = slot_shift[k];
    end
  end

  always_comb begin
    if (pte0[LARGE_BIT]) shift_out = large_sh;
    else if (base_shift == SHW'(SMALL_SH)) shift_out = SHW'(SMALL_SH);
    else shift_out = '0;
  end
endmodule

// File: rtl/pgsz_form.sv
module pgsz_form
  import pgsz_pkg::*;
(
  input  logic [SHW-1:0] shift,
  input  logic [XW-1:0]  pte1,
  input  logic [XW-1:0]  ea,
  output logic           ok,
  output logic [XW-1:0]  raddr,
  output logic [XW-1:0]  size
);
  localparam word_t RPN_M = rpn_field();

  word_t lm;

  always_comb begin
    lm = low_ones(shift);
    ok = (shift != '0);
    if (ok) begin
      raddr = ((pte1 & RPN_M) & ~lm) | (ea & lm);
      size  = word_t'(1) << shift;
    end else begin
      raddr = '0;
      size  = '0;
    end
  end
endmodule

// File: rtl/pte_pgsize_xlate.sv
module pte_pgsize_xlate
  import pgsz_pkg::*;
#(
  parameter int unsigned NUM_ENC = 8,
  parameter int unsigned ENC_W   = 16,
  localparam int unsigned IDX_W  = (NUM_ENC > 1) ? $clog2(NUM_ENC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [SHW-1:0]   cfg_shift,
  input  logic [ENC_W-1:0] cfg_enc,
  input  logic             cfg_base_we,
  input  logic [SHW-1:0]   cfg_base_shift,
  input  logic             req_valid,
  input  logic [XW-1:0]    req_pte0,
  input  logic [XW-1:0]    req_pte1,
  input  logic [XW-1:0]    req_ea,
  output logic             rsp_valid,
  output logic             rsp_ok,
  output logic             rsp_mchk,
  output logic [SHW-1:0]   rsp_shift,
  output logic [XW-1:0]    rsp_raddr,
  output logic [XW-1:0]    rsp_size
);
  logic [NUM_ENC-1:0][SHW-1:0]   t_shift;
  logic [NUM_ENC-1:0][ENC_W-1:0] t_enc;
  logic [SHW-1:0]                t_base;
  logic [SHW-1:0]                dec_shift;
  logic                          f_ok;
  logic [XW-1:0]                 f_raddr;
  logic [XW-1:0]                 f_size;

  pgsz_enc_table #(.NUM_ENC(NUM_ENC), .ENC_W(ENC_W)) u_tab (
    .clk(clk), .rst(rst), .we(cfg_we), .widx(cfg_idx), .wshift(cfg_shift),
    .wenc(cfg_enc), .base_we(cfg_base_we), .base_wshift(cfg_base_shift),
    .slot_shift(t_shift), .slot_enc(t_enc), .base_shift(t_base)
  );

  pgsz_scan #(.NUM_ENC(NUM_ENC), .ENC_W(ENC_W)) u_scan (
    .pte0(req_pte0), .pte1(req_pte1), .base_shift(t_base),
    .slot_shift(t_shift), .slot_enc(t_enc), .shift_out(dec_shift)
  );

  pgsz_form u_form (
    .shift(dec_shift), .pte1(req_pte1), .ea(req_ea),
    .ok(f_ok), .raddr(f_raddr), .size(f_size)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_mchk  <= 1'b0;
      rsp_shift <= '0;
      rsp_raddr <= '0;
      rsp_size  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_ok    <= f_ok;
        rsp_mchk  <= ~f_ok;
        rsp_shift <= dec_shift;
        rsp_raddr <= f_raddr;
        rsp_size  <= f_size;
      end
    end
  end
endmodule

// File: rtl/pgsz_chk.sv
module pgsz_chk
  import pgsz_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic [XW-1:0]  req_pte0,
  input logic           rsp_valid,
  input logic           rsp_ok,
  input logic           rsp_mchk,
  input logic [SHW-1:0] rsp_shift,
  input logic [XW-1:0]  rsp_raddr,
  input logic [XW-1:0]  rsp_size
);
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r2_hold_outputs: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(rsp_shift) && $stable(rsp_raddr) && $stable(rsp_size)
                    && $stable(rsp_ok) && $stable(rsp_mchk)));
  a_r3_small_page: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_pte0[LARGE_BIT]) |=> (rsp_shift == SHW'(SMALL_SH) || rsp_mchk));
  a_r7_no_small_when_large: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_pte0[LARGE_BIT]) |=> (rsp_shift != SHW'(SMALL_SH)));
  a_r10_mchk_clean: assert property (@(posedge clk) disable iff (rst)
    rsp_mchk |-> (!rsp_ok && rsp_shift == '0 && rsp_raddr == '0 && rsp_size == '0));
  a_r10_ok_nonzero: assert property (@(posedge clk) disable iff (rst)
    rsp_ok |-> (!rsp_mchk && rsp_shift != '0));
  a_r12_size_pow2: assert property (@(posedge clk) disable iff (rst)
    rsp_ok |-> ($countones(rsp_size) == 1));
  a_r11_high_clear: assert property (@(posedge clk) disable iff (rst)
    (rsp_ok && rsp_shift <= SHW'(RPN_HI + 1)) |-> (rsp_raddr[XW-1:RPN_HI+1] == '0));
endmodule

bind pte_pgsize_xlate pgsz_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_pte0(req_pte0),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_mchk(rsp_mchk),
  .rsp_shift(rsp_shift), .rsp_raddr(rsp_raddr), .rsp_size(rsp_size)
);

// File: tb/tb_pte_pgsize_xlate.sv
module tb_pte_pgsize_xlate;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned RPNM = 64'h00FF_FFFF_FFFF_F000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [5:0]  cfg_shift = '0;
  logic [15:0] cfg_enc = '0;
  logic        cfg_base_we = 1'b0;
  logic [5:0]  cfg_base_shift = '0;
  logic        req_valid = 1'b0;
  logic [63:0] req_pte0 = '0, req_pte1 = '0, req_ea = '0;
  logic        rsp_valid, rsp_ok, rsp_mchk;
  logic [5:0]  rsp_shift;
  logic [63:0] rsp_raddr, rsp_size;

  pte_pgsize_xlate dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference state
  int              m_sh[8];
  longint unsigned m_en[8];
  int              m_base;
  logic            e_valid, e_ok, e_mchk;
  logic [5:0]      e_shift;
  logic [63:0]     e_raddr, e_size;
  string           cur_tag = "R1";
  string           e_tag = "R1";
  int              n_cmp = 0, n_bad = 0, cyc = 0;
  bit              done = 0;

  function automatic int ref_shift(input logic [63:0] p0, input logic [63:0] p1);
    if (!p0[2]) return (m_base == 12) ? 12 : 0;
    for (int i = 0; i < 8; i++) begin
      longint unsigned mk;
      if (m_sh[i] == 0) return 0;
      if (m_sh[i] == 12) continue;
      mk = ((64'h1 << m_sh[i]) - 64'h1) & RPNM;
      if ((p1 & mk) == (m_en[i] << 12)) return m_sh[i];
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) begin m_sh[i] <= 0; m_en[i] <= 0; end
      m_base <= 12;
      e_valid <= 0; e_ok <= 0; e_mchk <= 0; e_shift <= 0; e_raddr <= 0; e_size <= 0;
      e_tag <= "R1";
    end else begin
      e_valid <= req_valid;
      if (req_valid) begin
        int s;
        longint unsigned lm;
        s  = ref_shift(req_pte0, req_pte1);
        lm = (64'h1 << s) - 64'h1;
        e_tag   <= cur_tag;
        e_ok    <= (s != 0);
        e_mchk  <= (s == 0);
        e_shift <= 6'(s);
        e_raddr <= (s == 0) ? 64'h0 : (((req_pte1 & RPNM) & ~lm) | (req_ea & lm));
        e_size  <= (s == 0) ? 64'h0 : (64'h1 << s);
      end else begin
        e_tag <= "R2";
      end
      if (cfg_we) begin m_sh[cfg_idx] <= int'(cfg_shift); m_en[cfg_idx] <= 64'(cfg_enc); end
      if (cfg_base_we) m_base <= int'(cfg_base_shift);
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", e_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 2 && !done) begin
      chk("rsp_valid", 64'(rsp_valid), 64'(e_valid));
      chk("rsp_ok",    64'(rsp_ok),    64'(e_ok));
      chk("rsp_mchk",  64'(rsp_mchk),  64'(e_mchk));
      chk("rsp_shift", 64'(rsp_shift), 64'(e_shift));
      chk("rsp_raddr", rsp_raddr, e_raddr);
      chk("rsp_size",  rsp_size,  e_size);
    end
  end

  task automatic wr_slot(input int idx, input int sh, input int enc);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_shift = 6'(sh); cfg_enc = 16'(enc);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wr_base(input int sh);
    @(negedge clk);
    cfg_base_we = 1; cfg_base_shift = 6'(sh);
    @(negedge clk);
    cfg_base_we = 0;
  endtask

  task automatic req(input logic [63:0] p0, input logic [63:0] p1,
                     input logic [63:0] ea, input string tag);
    @(negedge clk);
    req_valid = 1; req_pte0 = p0; req_pte1 = p1; req_ea = ea; cur_tag = tag;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);                 // R1: reset values compared
    req(64'h0, 64'h0000_1234_5678_9000, 64'hFFFF_FFFF_FFFF_FABC, "R3");
    repeat (2) @(negedge clk);                 // R2: hold
    wr_base(16);
    req(64'h0, 64'h0000_0000_0001_0000, 64'h1, "R4 R10");
    // Slots: 0:12/0 (skipped), 1:16/1, 2:24/0, 3:20/1, 4:end, 5:28/5
    wr_slot(0, 12, 0);
    wr_slot(1, 16, 1);
    wr_slot(2, 24, 0);
    wr_slot(3, 20, 1);
    wr_slot(5, 28, 5);
    req(64'h4, 64'hFF00_00AB_CDE0_1000, 64'h0123_4567_89AB_CDEF, "R5 R11 R12");
    req(64'h4, 64'h0000_0077_7000_0000, 64'hFEDC_BA98_7654_3210, "R8 R11");
    req(64'h4, 64'h0000_0000_0010_0000, 64'h5, "R7 R9");
    req(64'h4, 64'h0000_0000_0000_5000, 64'h9, "R6 R9");
    // Rewrite of the terminator with a request in the same cycle
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'd4; cfg_shift = 6'd28; cfg_enc = 16'd5;
    req_valid = 1; req_pte0 = 64'h4; req_pte1 = 64'h0000_0000_0000_5000; cur_tag = "R13";
    @(negedge clk);
    cfg_we = 0;
    req_pte1 = 64'h0000_0000_0000_5000; req_ea = 64'h0FFF_FFFF; // back-to-back, R2 R13
    @(negedge clk);
    req_valid = 0;
    wr_base(12);
    req(64'h0, 64'h0000_0000_0000_0000, 64'hABC, "R3");
    // R5: random traffic with crafted encodings
    for (int n = 0; n < 300; n++) begin
      logic [63:0] p1;
      p1 = {$urandom, $urandom};
      p1[27:12] = (n % 4 == 0) ? 16'h0001 : (n % 4 == 1) ? 16'h0000 :
                  (n % 4 == 2) ? 16'h0005 : 16'h0100;
      req({61'($urandom), 1'(n % 5 != 0), 2'b0}, p1, {$urandom, $urandom}, "R5");
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule